// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Write Guard

This block is a slave on a two-wire serial bus (open-drain data line, master-driven clock) that fronts a 272-byte register array organised as 17 pages of 16 bytes. The array is split into four regions: general storage at 000h–07Fh, a control and status window at 080h–08Fh, a first lookup table at 090h–0CFh and a second lookup table at 0D0h–10Fh. Both lines are sampled by the block's own clock. The block detects START and STOP, matches a device byte against a fixed type code and three strap pins, and acknowledges each byte it accepts.

A transaction carries one address byte, which reaches only 256 locations. A bank bit in the configuration byte at 087h therefore redirects addresses 00h–0Fh to 100h–10Fh. Bit 7 of the same byte is a write guard: it must be set before any other location accepts data. The reserved bytes 088h–08Fh never accept data and read as zero. Sequential writes stay inside their 16-byte page. Sequential reads run through the whole array and wrap from its last byte to its first.

Top module: `twi_mem_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) at any point, a repeated START included, restarts device-byte reception and discards any partial byte. A STOP (SDA rising while SCL is high) at any point returns the slave to idle with SDA released.
- R2: The device byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `strap_i`. Bit 0 selects read (1) or write (0). On a mismatch there is no acknowledge, and SDA stays released until the next START.
- R3: Bytes are shifted most-significant bit first. The slave acknowledges the matching device byte, the address byte and every write data byte by pulling SDA low during the ninth clock.
- R4: The address byte loads the pointer. When bank bit 0 of byte 087h is 1 and the address byte is 00h–0Fh, the pointer becomes 100h plus the address byte. Otherwise the pointer equals the address byte.
- R5: A write to byte 087h is always stored. A write to any other location is stored only while guard bit 7 of byte 087h is 1; otherwise it is dropped, but still acknowledged.
- R6: Writes to 088h–08Fh have no effect, and reads of 088h–08Fh return 00h.
- R7: After each written byte, the pointer's low four bits advance modulo 16 and its page bits are kept, so a sequential write wraps within its page.
- R8: After each read byte, the pointer advances by one and wraps from 10Fh to 000h, so sequential reads cross page boundaries.
- R9: After reset every array byte is 00h (lookup tables, guard bit and bank bit included), and SDA is released.
- R10: During a read, the master's acknowledge bit controls what follows. A low bit makes the slave send the next byte. A high bit (NACK) makes the slave release SDA and wait for the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples both bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Device address straps compared with device byte bits 3:1 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions check on every cycle that a detected STOP leaves SDA released in the next cycle, and that a START re-arms device-byte reception. They also check that a mismatched device byte never leads to SDA being driven, and that a write never moves the pointer off its page. In the array, a write while the guard is clear, or a write to a reserved byte, must leave the addressed byte unchanged, and the pointer must stay inside the array. Only the bench's scenarios can show the end-to-end effects: data stored while the guard is set and dropped while it is clear, the bank redirection, the 10Fh-to-000h read wrap, partial bytes discarded on STOP or repeated START, and the master's NACK ending a read.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    localparam int PAGE_BYTES = 16;
    localparam int PAGES      = 17;
    localparam int DEPTH      = PAGE_BYTES * PAGES;
    localparam int AW         = $clog2(DEPTH);
    localparam int OFF_W      = $clog2(PAGE_BYTES);

    typedef logic [AW-1:0] ptr_t;
    typedef logic [7:0]    byte_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam ptr_t CFG_ADDR = ptr_t'(9'h087);
    localparam ptr_t RSV_LO   = ptr_t'(9'h088);
    localparam ptr_t RSV_HI   = ptr_t'(9'h08F);
    localparam int   GUARD_BIT = 7;
    localparam int   BANK_BIT  = 0;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_ACK_DEV,
        PH_ADDR,
        PH_ACK_ADDR,
        PH_WDATA,
        PH_ACK_WR,
        PH_RDATA,
        PH_RACK
    } phase_e;

    function automatic logic is_rsvd(input ptr_t p);
        return (p >= RSV_LO) && (p <= RSV_HI);
    endfunction

    function automatic ptr_t map_ptr(input logic bank, input byte_t a);
        if (bank && (a[7:OFF_W] == '0))
            return ptr_t'(DEPTH - PAGE_BYTES) + ptr_t'(a[OFF_W-1:0]);
        return ptr_t'(a);
    endfunction

    function automatic ptr_t next_wr(input ptr_t p);
        logic [OFF_W-1:0] off;
        off = p[OFF_W-1:0] + 1'b1;
        return {p[AW-1:OFF_W], off};
    endfunction

    function automatic ptr_t next_rd(input ptr_t p);
        return (p == ptr_t'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;
    localparam int SCL = 0;
    localparam int SDA = 1;

    logic [LINES-1:0] raw, s1, s2, prev;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[g]   <= 1'b1;
                s2[g]   <= 1'b1;
                prev[g] <= 1'b1;
            end else begin
                s1[g]   <= raw[g];
                s2[g]   <= s1[g];
                prev[g] <= s2[g];
            end
        end
    end

    assign sda_s     = s2[SDA];
    assign scl_rise  = s2[SCL] & ~prev[SCL];
    assign scl_fall  = ~s2[SCL] & prev[SCL];
    assign start_det = s2[SCL] & prev[SCL] & prev[SDA] & ~s2[SDA];
    assign stop_det  = s2[SCL] & prev[SCL] & ~prev[SDA] & s2[SDA];
endmodule

// File: rtl/twi_byte_array.sv
module twi_byte_array
    import twi_mem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ptr_t  waddr,
    input  byte_t wdata,
    input  ptr_t  raddr,
    output byte_t rdata,
    output logic  bank
);
    byte_t mem [DEPTH];
    logic  guard;
    logic  accept;

    assign guard  = mem[CFG_ADDR][GUARD_BIT];
    assign bank   = mem[CFG_ADDR][BANK_BIT];
    assign accept = (waddr == CFG_ADDR) || (guard && !is_rsvd(waddr));
    assign rdata  = is_rsvd(raddr) ? 8'h00 : mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && accept) begin
            mem[waddr] <= wdata;
        end
    end

    // R5: guard clear blocks every location except the config byte
    a_r5_locked_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (we && !guard && waddr != CFG_ADDR) |=> mem[$past(waddr)] == $past(mem[waddr]));

    // R6: reserved bytes never change
    a_r6_reserved_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (we && is_rsvd(waddr)) |=> mem[$past(waddr)] == $past(mem[waddr]));
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
    import twi_mem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [2:0] strap,
    input  byte_t      rd_data,
    input  logic       bank,
    output logic       we,
    output ptr_t       ptr,
    output byte_t      wdata,
    output logic       sda_oe
);
    phase_e     phase;
    logic [3:0] cnt;
    byte_t      sh, tx;
    logic       rw, nack;
    logic       byte_end, dev_match;

    assign byte_end  = scl_fall && (cnt == 4'd8);
    assign dev_match = (sh[7:4] == DEV_TYPE) && (sh[3:1] == strap);
    assign we        = (phase == PH_WDATA) && byte_end && !start_det && !stop_det;
    assign wdata     = sh;
    assign sda_oe    = (phase == PH_ACK_DEV) || (phase == PH_ACK_ADDR) ||
                       (phase == PH_ACK_WR) || ((phase == PH_RDATA) && !tx[7]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            sh    <= '0;
            tx    <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            nack  <= 1'b0;
        end else if (start_det) begin
            phase <= PH_DEV;
            cnt   <= '0;
        end else if (stop_det) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_DEV, PH_ADDR, PH_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt <= '0;
                        if (phase == PH_DEV) begin
                            if (dev_match) begin
                                rw    <= sh[0];
                                phase <= PH_ACK_DEV;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else if (phase == PH_ADDR) begin
                            ptr   <= map_ptr(bank, sh);
                            phase <= PH_ACK_ADDR;
                        end else begin
                            ptr   <= next_wr(ptr);
                            phase <= PH_ACK_WR;
                        end
                    end
                end
                PH_ACK_DEV: begin
                    if (scl_fall) begin
                        if (rw) begin
                            tx    <= rd_data;
                            phase <= PH_RDATA;
                        end else begin
                            phase <= PH_ADDR;
                        end
                    end
                end
                PH_ACK_ADDR, PH_ACK_WR: begin
                    if (scl_fall) phase <= PH_WDATA;
                end
                PH_RDATA: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt   <= '0;
                        ptr   <= next_rd(ptr);
                        phase <= PH_RACK;
                    end else if (scl_fall) begin
                        tx <= {tx[6:0], 1'b0};
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        nack <= sda_s;
                    end else if (scl_fall) begin
                        if (nack) begin
                            phase <= PH_IDLE;
                        end else begin
                            tx    <= rd_data;
                            phase <= PH_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: STOP releases the data line on the next cycle
    a_r1_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R1: START re-arms device-byte reception from bit zero
    a_r1_start_rearm: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (phase == PH_DEV) && (cnt == 4'd0));

    // R2: a mismatched device byte never leads to driving SDA
    a_r2_mismatch_quiet: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_DEV) && byte_end && !dev_match && !start_det && !stop_det) |=> !sda_oe);

    // R7: a written byte keeps the pointer on its page
    a_r7_write_stays_in_page: assert property (@(posedge clk) disable iff (rst)
        we |=> ptr[AW-1:OFF_W] == $past(ptr[AW-1:OFF_W]));

    // R8: the pointer never leaves the array
    a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        ptr < ptr_t'(DEPTH));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    logic  sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic  we, bank;
    ptr_t  ptr;
    byte_t wdata, rdata;

    twi_line_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_proto_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap_i),
        .rd_data   (rdata),
        .bank      (bank),
        .we        (we),
        .ptr       (ptr),
        .wdata     (wdata),
        .sda_oe    (sda_oe_o)
    );

    twi_byte_array u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (ptr),
        .wdata (wdata),
        .raddr (ptr),
        .rdata (rdata),
        .bank  (bank)
    );
endmodule

// File: tb/twi_mem_slave_tb.sv
module twi_mem_slave_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b010;
    logic       sda_oe;
    logic       sda_line;

    localparam logic [7:0] DEV_W = 8'hA4;
    localparam logic [7:0] DEV_R = 8'hA5;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    twi_mem_slave u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(6);
        scl = 1'b1;   wt(12);
        sda_m = 1'b0; wt(12);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(7); sda_m = 1'b0; wt(5);
        scl = 1'b1; wt(12);
        sda_m = 1'b1; wt(12);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wt(7); sda_m = b[i]; wt(5);
            scl = 1'b1; wt(12);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        wt(7); sda_m = 1'b1; wt(5);
        scl = 1'b1; wt(6);
        ack = !sda_line; wt(6);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(12); scl = 1'b1; wt(6);
            b[i] = sda_line; wt(6);
            scl = 1'b0;
        end
        wt(7); sda_m = last; wt(5);
        scl = 1'b1; wt(12);
        scl = 1'b0;
        if (last) begin
            wt(6);
            chk("R10 released after NACK", sda_oe, 0);
        end
    endtask

    task automatic wr_seq(input logic [7:0] a, input logic [7:0] d0, d1, d2, input int n);
        bit ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte(DEV_W, ack); chk("R3 device ack (write)", ack, 1);
        send_byte(a, ack);     chk("R3 address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack); chk("R3 data ack", ack, 1);
        end
        bus_stop();
    endtask

    task automatic rd_seq(input logic [7:0] a, input int n, output logic [7:0] r [3]);
        bit ack;
        bus_start();
        send_byte(DEV_W, ack); chk("R3 device ack", ack, 1);
        send_byte(a, ack);     chk("R3 address ack", ack, 1);
        bus_start();
        send_byte(DEV_R, ack); chk("R1 repeated START read ack", ack, 1);
        for (int k = 0; k < n; k++) recv_byte(k == n - 1, r[k]);
        bus_stop();
    endtask

    task automatic rd1(input logic [7:0] a, input logic [7:0] exp, input string req);
        logic [7:0] r [3];
        rd_seq(a, 1, r);
        chk(req, r[0], exp);
    endtask

    task automatic t_reset();
        chk("R9 SDA released after reset", sda_oe, 0);
        rd1(8'h00, 8'h00, "R9 general byte zero");
        rd1(8'h90, 8'h00, "R9 table one zero");
        rd1(8'hD5, 8'h00, "R9 table two zero");
        rd1(8'h87, 8'h00, "R9 config zero");
    endtask

    task automatic t_addr_match();
        bit ack;
        bus_start();
        send_byte(8'hA8, ack); chk("R2 strap mismatch no ack", ack, 0);
        send_byte(8'h00, ack); chk("R2 stays released after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hB4, ack); chk("R2 type mismatch no ack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(DEV_W, ack); chk("R2 matching device ack", ack, 1);
        bus_stop();
    endtask

    task automatic t_guard();
        wr_seq(8'h10, 8'h5A, 8'h00, 8'h00, 1);
        rd1(8'h10, 8'h00, "R5 write dropped while guard clear");
        wr_seq(8'h87, 8'h80, 8'h00, 8'h00, 1);
        rd1(8'h87, 8'h80, "R5 config write always accepted");
        wr_seq(8'h10, 8'h5A, 8'h00, 8'h00, 1);
        rd1(8'h10, 8'h5A, "R5 write stored with guard set");
    endtask

    task automatic t_reserved();
        wr_seq(8'h8A, 8'hFF, 8'h00, 8'h00, 1);
        rd1(8'h8A, 8'h00, "R6 reserved write ignored");
        wr_seq(8'h8F, 8'hA5, 8'h00, 8'h00, 1);
        rd1(8'h8F, 8'h00, "R6 reserved reads zero");
    endtask

    task automatic t_page_wrap();
        wr_seq(8'h1E, 8'h11, 8'h22, 8'h33, 3);
        rd1(8'h1E, 8'h11, "R7 first byte");
        rd1(8'h1F, 8'h22, "R7 page end");
        rd1(8'h10, 8'h33, "R7 wrapped to page start");
        rd1(8'h20, 8'h00, "R7 next page untouched");
    endtask

    task automatic t_seq_read();
        logic [7:0] r [3];
        rd_seq(8'h1E, 3, r);
        chk("R8 seq read byte0", r[0], 8'h11);
        chk("R8 seq read byte1", r[1], 8'h22);
        chk("R8 seq read crosses page", r[2], 8'h00);
    endtask

    task automatic t_bank();
        logic [7:0] r [3];
        wr_seq(8'h00, 8'h77, 8'h00, 8'h00, 1);
        wr_seq(8'h87, 8'h81, 8'h00, 8'h00, 1);
        wr_seq(8'h0F, 8'hC3, 8'h00, 8'h00, 1);
        rd_seq(8'h0F, 2, r);
        chk("R4 bank reaches 10Fh", r[0], 8'hC3);
        chk("R8 read wraps 10Fh to 000h", r[1], 8'h77);
        wr_seq(8'h87, 8'h80, 8'h00, 8'h00, 1);
        rd1(8'h0F, 8'h00, "R4 bank clear maps to 00Fh");
        rd1(8'h00, 8'h77, "R4 bank clear direct 000h");
    endtask

    task automatic t_abort();
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h41, ack);
        send_bits(8'hFF, 3);
        bus_stop();
        rd1(8'h41, 8'h00, "R1 partial byte dropped on STOP");
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h42, ack);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(DEV_R, ack); chk("R1 START mid-byte re-arms", ack, 1);
        recv_byte(1'b1, b);
        chk("R1 partial byte dropped on START", b, 8'h00);
        bus_stop();
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset();
        t_addr_match();
        t_guard();
        t_reserved();
        t_page_wrap();
        t_seq_read();
        t_bank();
        t_abort();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule